// File: doc/BRIEF.md
# Saturating 40-bit Accumulator Adder

This block is a one-cycle accumulate stage for a DSP coprocessor datapath. It keeps a 40-bit two's-complement accumulator. Eight guard bits sit above a 32-bit working range. On each cycle with the strobe high, it adds an operand built from two 16-bit words. The high word supplies the upper half and the low word supplies the lower half, and the 32-bit result is sign-extended. A mode input can double the operand first.

When saturation is enabled, any sum outside the signed 32-bit range is replaced by the nearest limit of that range. The block also keeps six status flags. Three of them describe the value written: its sign, whether it is zero, and whether the guard bits are in use. The carry flag reflects the raw addition. Two flags are sticky and are cleared only by an explicit clear input: one records 40-bit overflow and one records saturation. A direct load input lets the controller preset the accumulator without changing any flag.

Top module: `sat_acc40`

## Requirements
- R1: After the active-low asynchronous reset, the accumulator and all six flags are zero.
- R2: The operand is the sign extension to 40 bits of the 32-bit word {hi, lo}. When the double input is high, that 40-bit operand is shifted left by one bit with a zero entering bit 0.
- R3: When the strobe is high and load is low, the accumulator takes (accumulator + operand) modulo 2^40 on the next edge, unless R4 applies.
- R4: When saturation is enabled and the exact signed sum of the accumulator and the operand is above 2^31-1, the accumulator becomes 0x00_7FFF_FFFF. When that sum is below -2^31, the accumulator becomes 0xFF_8000_0000.
- R5: The flags output holds N at bit 0, Z at bit 1, C at bit 2, SV at bit 3, E at bit 4 and SL at bit 5. On an add, N, Z and E are computed from the value written to the accumulator. N is bit 39 of that value. Z is set when the value is zero. E is set when bits 39 down to 31 are not all equal.
- R6: On an add, C is set to the carry out of the unsigned 40-bit addition of the accumulator and the operand.
- R7: SV is set by an add whose exact signed sum lies outside the 40-bit signed range. Otherwise it keeps its value.
- R8: SL is set by an add that saturates under R4. Otherwise it keeps its value.
- R9: The sticky-clear input clears SV and SL on the next edge. If an add in the same cycle sets either flag, that flag ends up set.
- R10: When load is high, the accumulator takes the load value and N, Z, C and E keep their values. Load takes precedence over the strobe.
- R11: With the strobe and load both low, the accumulator and N, Z, C and E hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Add strobe |
| dbl_i | input | 1 | Double the operand before the add |
| sat_en_i | input | 1 | Enable 32-bit saturation |
| op_lo_i | input | 16 | Low operand word |
| op_hi_i | input | 16 | High operand word |
| load_i | input | 1 | Direct accumulator load |
| load_val_i | input | 40 | Value for direct load |
| clr_sticky_i | input | 1 | Clear the SV and SL flags |
| acc_o | output | 40 | Accumulator |
| flags_o | output | 6 | {SL, E, SV, C, Z, N} |

## Verification
The assertions assume that every input is stable and known at each rising edge. They also assume that a load and a strobe may arrive in the same cycle, with the load taking precedence. The bench drives all inputs on the falling edge, so each input is settled before the edge that samples it. The stimulus deliberately includes simultaneous load and strobe, and clears that coincide with overflow. Preloaded accumulator values already use the guard bits, so the saturation path and the 40-bit overflow path are both reached from states that random adds alone would seldom produce.

// File: rtl/sat_acc40_pkg.sv
package sat_acc40_pkg;
  // bit 0 = n ... bit 5 = sl
  typedef struct packed {
    logic sl;
    logic e;
    logic sv;
    logic c;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/sat_acc40_operand.sv
module sat_acc40_operand #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic              dbl_i,
  output logic [ACC_W-1:0]  op_o
);
  localparam int OP_W  = 2 * WORD_W;
  localparam int EXT_W = ACC_W - OP_W;

  logic [OP_W-1:0]  word;
  logic [ACC_W-1:0] ext;

  assign word = {hi_i, lo_i};

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext = {{EXT_W{word[OP_W-1]}}, word};
    end else begin : g_noext
      assign ext = word[ACC_W-1:0];
    end
  endgenerate

  assign op_o = dbl_i ? {ext[ACC_W-2:0], 1'b0} : ext;
endmodule

// File: rtl/sat_acc40_adder.sv
module sat_acc40_adder #(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] op_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             sat_o
);
  localparam int TOP_W = ACC_W - SAT_W + 2;  // bits of exact sum above the 32-bit sign
  localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic [ACC_W:0]   usum;
  logic [ACC_W:0]   xsum;  // exact signed sum
  logic [TOP_W-1:0] top;
  logic             out_rng;

  assign usum    = {1'b0, acc_i} + {1'b0, op_i};
  assign xsum    = {acc_i[ACC_W-1], acc_i} + {op_i[ACC_W-1], op_i};
  assign carry_o = usum[ACC_W];
  assign ovf_o   = xsum[ACC_W] ^ xsum[ACC_W-1];
  assign top     = xsum[ACC_W:SAT_W-1];
  assign out_rng = ~((&top) | ~(|top));
  assign sat_o   = sat_en_i & out_rng;

  always_comb begin
    if (sat_o) res_o = xsum[ACC_W] ? NEG_LIM : POS_LIM;
    else       res_o = xsum[ACC_W-1:0];
  end
endmodule

// File: rtl/sat_acc40_status.sv
module sat_acc40_status
  import sat_acc40_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] res_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic             sat_i,
  output flags_t           flags_o
);
  localparam int GRD_W = ACC_W - SAT_W + 1;

  flags_t q, d;
  logic [GRD_W-1:0] grd;

  assign grd = res_i[ACC_W-1:SAT_W-1];

  always_comb begin
    d = q;
    if (clr_i) begin
      d.sv = 1'b0;
      d.sl = 1'b0;
    end
    if (upd_i) begin
      d.n  = res_i[ACC_W-1];
      d.z  = ~|res_i;
      d.c  = carry_i;
      d.e  = ~((&grd) | ~(|grd));
      d.sv = d.sv | ovf_i;
      d.sl = d.sl | sat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign flags_o = q;

  AST_SV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(q.sv));  // R7
  AST_SL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(q.sl));  // R8
  AST_STICKY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !upd_i) |=> (!q.sv && !q.sl));  // R9
  AST_SV_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && ovf_i) |=> q.sv);  // R7
endmodule

// File: rtl/sat_acc40.sv
module sat_acc40
  import sat_acc40_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 40,
  parameter int SAT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              dbl_i,
  input  logic              sat_en_i,
  input  logic [WORD_W-1:0] op_lo_i,
  input  logic [WORD_W-1:0] op_hi_i,
  input  logic              load_i,
  input  logic [ACC_W-1:0]  load_val_i,
  input  logic              clr_sticky_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [5:0]        flags_o
);
  localparam int GRD_W = ACC_W - SAT_W + 1;

  logic [ACC_W-1:0] acc_q, op, res;
  logic             carry, ovf, sat, upd;
  flags_t           flags;

  assign upd = valid_i & ~load_i;

  sat_acc40_operand #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_operand (
    .lo_i (op_lo_i),
    .hi_i (op_hi_i),
    .dbl_i(dbl_i),
    .op_o (op)
  );

  sat_acc40_adder #(.ACC_W(ACC_W), .SAT_W(SAT_W)) i_adder (
    .acc_i   (acc_q),
    .op_i    (op),
    .sat_en_i(sat_en_i),
    .res_o   (res),
    .carry_o (carry),
    .ovf_o   (ovf),
    .sat_o   (sat)
  );

  sat_acc40_status #(.ACC_W(ACC_W), .SAT_W(SAT_W)) i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .clr_i  (clr_sticky_i),
    .res_i  (res),
    .carry_i(carry),
    .ovf_i  (ovf),
    .sat_i  (sat),
    .flags_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= load_val_i;
    else if (valid_i) acc_q <= res;
  end

  assign acc_o   = acc_q;
  assign flags_o = flags;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !load_i) |=> $stable(acc_o));  // R11
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_o == $past(load_val_i)));  // R10
  AST_SAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && sat_en_i) |=> ((&acc_o[ACC_W-1:SAT_W-1]) || !(|acc_o[ACC_W-1:SAT_W-1])));  // R4
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[1] == (acc_o == '0)));  // R5
  AST_EXT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[4] == !((&acc_o[ACC_W-1:ACC_W-GRD_W]) || !(|acc_o[ACC_W-1:ACC_W-GRD_W]))));  // R5
  AST_SIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[0] == acc_o[ACC_W-1]));  // R5
endmodule

// File: tb/test_sat_acc40.sv
module test_sat_acc40;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, dbl_i = 1'b0, sat_en_i = 1'b0;
  logic [15:0] op_lo_i = '0, op_hi_i = '0;
  logic        load_i = 1'b0, clr_sticky_i = 1'b0;
  logic [39:0] load_val_i = '0;
  logic [39:0] acc_o;
  logic [5:0]  flags_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [39:0] m_acc = '0;
  logic [5:0]  m_f = '0;  // {SL,E,SV,C,Z,N}

  always #5 clk_i = ~clk_i;

  sat_acc40 i_sat_acc40 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(input string acc_req);
    chk(acc_req, {24'd0, acc_o}, {24'd0, m_acc});
    chk("R5 N", {63'd0, flags_o[0]}, {63'd0, m_f[0]});
    chk("R5 Z", {63'd0, flags_o[1]}, {63'd0, m_f[1]});
    chk("R6 C", {63'd0, flags_o[2]}, {63'd0, m_f[2]});
    chk("R7 SV", {63'd0, flags_o[3]}, {63'd0, m_f[3]});
    chk("R5 E", {63'd0, flags_o[4]}, {63'd0, m_f[4]});
    chk("R8 SL", {63'd0, flags_o[5]}, {63'd0, m_f[5]});
  endtask

  // drive at negedge, model update, check at next negedge
  task automatic step(input logic v, input logic d, input logic s, input logic ld,
                      input logic [39:0] lv, input logic cl,
                      input logic [15:0] hi, input logic [15:0] lo, input string req);
    longint a, op, t, m40, ucar;
    logic [63:0] tv;
    logic [39:0] r;
    logic ov, sa;
    valid_i = v; dbl_i = d; sat_en_i = s; load_i = ld; load_val_i = lv;
    clr_sticky_i = cl; op_hi_i = hi; op_lo_i = lo;
    a  = longint'($signed(m_acc));
    op = longint'($signed({hi, lo}));
    if (d) op = op * 2;
    t  = a + op;
    m40 = (longint'(1) <<< 40) - 1;
    ucar = (((a & m40) + (op & m40)) >>> 40) & 1;
    ov = (t > (longint'(1) <<< 39) - 1) || (t < -(longint'(1) <<< 39));
    sa = s && ((t > 64'sd2147483647) || (t < -64'sd2147483648));
    tv = t;
    r  = sa ? ((t > 0) ? 40'h007FFFFFFF : 40'hFF80000000) : tv[39:0];
    if (cl) begin m_f[3] = 1'b0; m_f[5] = 1'b0; end
    if (ld) m_acc = lv;
    else if (v) begin
      m_acc  = r;
      m_f[0] = r[39];
      m_f[1] = (r == '0);
      m_f[2] = ucar[0];
      m_f[4] = !((&r[39:31]) || !(|r[39:31]));
      m_f[3] = m_f[3] | ov;
      m_f[5] = m_f[5] | sa;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    compare(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    compare("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 reset");

    step(1, 0, 0, 0, '0, 0, 16'h0001, 16'h2345, "R3 add");
    step(1, 0, 0, 0, '0, 0, 16'h0000, 16'h0001, "R3 add");
    step(1, 1, 0, 0, '0, 0, 16'h0000, 16'h0010, "R2 double");
    step(1, 0, 0, 0, '0, 0, 16'hFFFF, 16'hFFFF, "R2 sign extension");
    step(1, 1, 0, 0, '0, 0, 16'h8000, 16'h0000, "R2 double negative");
    step(0, 0, 0, 0, '0, 0, 16'h1234, 16'h5678, "R11 idle");
    step(0, 0, 0, 1, 40'hFF_FFFF_FFFF, 0, 16'h0, 16'h0, "R10 load");
    step(1, 0, 0, 0, '0, 0, 16'h0000, 16'h0001, "R6 carry to zero");
    step(1, 0, 0, 1, 40'h00_0000_0005, 0, 16'h7FFF, 16'hFFFF, "R10 load over add");
    step(0, 0, 0, 1, 40'h00_7FFF_FFF0, 0, 16'h0, 16'h0, "R10 load");
    step(1, 0, 1, 0, '0, 0, 16'h0000, 16'h0100, "R4 positive clamp");
    step(0, 0, 0, 1, 40'hFF_8000_0010, 0, 16'h0, 16'h0, "R10 load");
    step(1, 0, 1, 0, '0, 0, 16'hFFFF, 16'hFF00, "R4 negative clamp");
    step(0, 0, 0, 0, '0, 1, 16'h0, 16'h0, "R9 clear");
    step(0, 0, 0, 1, 40'h00_7FFF_FFF0, 0, 16'h0, 16'h0, "R10 load");
    step(1, 0, 0, 0, '0, 0, 16'h0000, 16'h0100, "R5 guard bits in use");
    step(0, 0, 0, 1, 40'h7F_FFFF_FFFF, 0, 16'h0, 16'h0, "R10 load");
    step(1, 0, 0, 0, '0, 0, 16'h0000, 16'h0001, "R7 40-bit overflow");
    step(0, 0, 0, 1, 40'h7F_FFFF_FF00, 0, 16'h0, 16'h0, "R10 load");
    step(1, 1, 1, 0, '0, 1, 16'h7FFF, 16'hFFFF, "R9 clear with new event");
    step(1, 0, 0, 0, '0, 0, 16'h0000, 16'h0000, "R8 sticky held");
    step(0, 0, 0, 1, 40'h00_0000_0003, 1, 16'h0, 16'h0, "R9 clear on load");
    step(1, 0, 0, 0, '0, 0, 16'hFFFF, 16'hFFFD, "R5 zero result");

    for (int i = 0; i < 3000; i++) begin
      logic [39:0] lv;
      lv = {$urandom() % 256, $urandom()};
      step(($urandom() % 4) != 0, $urandom() % 2, $urandom() % 2,
           ($urandom() % 10) == 0, lv, ($urandom() % 16) == 0,
           $urandom(), $urandom(), "R3 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule